// File: doc/BRIEF.md
# PHY Register Access Controller

This block gives a host processor a single 32-bit control and status word for reaching the internal registers of an attached physical-layer device. The host writes a 4-bit PHY register address and an 8-bit write value into the low half of the word. In the same write it sets one of two request bits, one for a read and one for a write. The block then presents the request on a request/acknowledge port toward the PHY side. It holds the request there until the PHY side acknowledges it, and then clears the request bit on its own.

In the other direction, the PHY side delivers register transfers as one-cycle strobes. Each strobe carries an address and a data byte. The block stores the most recent pair in the upper half of the word and raises a done flag there. The done flag drops when the host launches a new request. The upper half is written only by hardware, so host writes never reach it.

A small state machine tracks the request. It has three states: `ST_IDLE` (no request outstanding), `ST_RD_PEND` (a read request is presented) and `ST_WR_PEND` (a write request is presented). An accepted host write moves the machine from `ST_IDLE` to `ST_RD_PEND` when the read bit is set (transition *launch read*). It moves to `ST_WR_PEND` when only the write bit is set (transition *launch write*). From either pending state, an acknowledge returns the machine to `ST_IDLE` (transition *acknowledged*). In every other case the machine stays in its state.

Top module: `phy_reg_access`

## Requirements
- R1: After reset the word reads as 0x00000000 at its offset, and `phy_req_valid` is 0.
- R2: In `ST_IDLE`, a host write at offset 0xEC with bit 15 set asserts `phy_req_valid` with `phy_req_is_read`=1 and `phy_req_addr` equal to bits 11–8 of that write, from the next cycle on. Bit 15 reads back as 1 until the cycle after `phy_req_ack`; then bit 15 and `phy_req_valid` are 0.
- R3: In `ST_IDLE`, a host write with bit 14 set and bit 15 clear asserts `phy_req_valid` with `phy_req_is_read`=0, and presents bits 11–8 as `phy_req_addr` and bits 7–0 as `phy_req_data`. Bit 14 reads back as 1 until the cycle after the acknowledge.
- R4: An accepted host write that launches a request clears the done flag (bit 31) in the next cycle.
- R5: A `phy_rsp_valid` strobe sets bit 31 and loads bits 27–24 with `phy_rsp_addr` and bits 23–16 with `phy_rsp_data`. This holds even when the strobe falls in the same cycle as a launching host write.
- R6: Host writes to bits 31–16 have no effect on those bits.
- R7: Bits 30–28 and 13–12 always read as 0, even after a write of ones to them.
- R8: A launching write with both bits 15 and 14 set starts a read request only: `phy_req_is_read`=1, and bit 14 reads 0.
- R9: While a request is pending, host writes to the word are ignored. The address, data and request bits are unchanged, and no second request follows the acknowledge.
- R10: Host writes at any other offset change nothing, and reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host byte offset for reads and writes |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| phy_req_valid | output | 1 | A request is presented to the PHY side |
| phy_req_is_read | output | 1 | 1 for a read request, 0 for a write request |
| phy_req_addr | output | 4 | PHY register address of the request |
| phy_req_data | output | 8 | Write data of the request |
| phy_req_ack | input | 1 | One-cycle acknowledge from the PHY side |
| phy_rsp_valid | input | 1 | One-cycle strobe of an incoming register transfer |
| phy_rsp_addr | input | 4 | Address of the incoming transfer |
| phy_rsp_data | input | 8 | Data of the incoming transfer |

## Verification
The assertions assume that `phy_req_ack` is asserted only while `phy_req_valid` is high, and that it lasts a single cycle. They also assume that `host_wr` and `phy_rsp_valid` are single-cycle strobes that are never X after reset. The stimulus keeps to these rules: it drives every input on the falling clock edge, raises the acknowledge only after it has seen a presented request, and holds each strobe for exactly one cycle. The stimulus also covers the corner cases deliberately. It writes while a request is pending, places a transfer strobe in the same cycle as a launching write, and sets both request bits in one write.

// File: rtl/phy_reg_pkg.sv
package phy_reg_pkg;
    localparam int REG_W      = 32;
    localparam int PHY_AW     = 4;
    localparam int PHY_DW     = 8;

    localparam int DONE_BIT   = 31;
    localparam int RSPA_LSB   = 24;
    localparam int RSPD_LSB   = 16;
    localparam int RDREQ_BIT  = 15;
    localparam int WRREQ_BIT  = 14;
    localparam int REQA_LSB   = 8;
    localparam int REQD_LSB   = 0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_PEND = 2'd1,
        ST_WR_PEND = 2'd2
    } req_state_e;
endpackage

// File: rtl/phy_req_fsm.sv
module phy_req_fsm
    import phy_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_rd,
    input  logic launch_wr,
    input  logic req_ack,
    output logic req_valid,
    output logic req_is_read,
    output logic fsm_idle,
    output logic rd_pend,
    output logic wr_pend
);
    req_state_e state_q, state_nxt;

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_rd)      state_nxt = ST_RD_PEND;
                else if (launch_wr) state_nxt = ST_WR_PEND;
            end
            ST_RD_PEND: if (req_ack) state_nxt = ST_IDLE;
            ST_WR_PEND: if (req_ack) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // outputs
    always_comb begin
        req_valid   = 1'b0;
        req_is_read = 1'b0;
        fsm_idle    = 1'b0;
        rd_pend     = 1'b0;
        wr_pend     = 1'b0;
        unique case (state_q)
            ST_IDLE:    fsm_idle = 1'b1;
            ST_RD_PEND: begin req_valid = 1'b1; req_is_read = 1'b1; rd_pend = 1'b1; end
            ST_WR_PEND: begin req_valid = 1'b1; wr_pend = 1'b1; end
            default:    fsm_idle = 1'b1;
        endcase
    end

    // R2 / R3: acknowledge of a presented request returns to idle
    a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> (fsm_idle && !req_valid));

    // R3: a write launch from idle presents a write request
    a_r3_write_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && launch_wr && !launch_rd) |=> (req_valid && !req_is_read));

    // R2: a request never appears without a launch
    a_r2_valid_from_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !(fsm_idle && (launch_rd || launch_wr))) |=> !req_valid);
endmodule

// File: rtl/phy_rsp_capture.sv
module phy_rsp_capture
    import phy_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              rsp_valid,
    input  logic [PHY_AW-1:0] rsp_addr,
    input  logic [PHY_DW-1:0] rsp_data,
    output logic              done_q,
    output logic [PHY_AW-1:0] rsp_addr_q,
    output logic [PHY_DW-1:0] rsp_data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            rsp_addr_q <= '0;
            rsp_data_q <= '0;
        end else begin
            if (rsp_valid) begin
                done_q     <= 1'b1;
                rsp_addr_q <= rsp_addr;
                rsp_data_q <= rsp_data;
            end else if (launch) begin
                done_q     <= 1'b0;
            end
        end
    end

    // R4: a launch without an incoming transfer clears done
    a_r4_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !rsp_valid) |=> !done_q);

    // R5: an incoming transfer sets done and captures its fields
    a_r5_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (done_q && rsp_addr_q == $past(rsp_addr) && rsp_data_q == $past(rsp_data)));

    // R6: captured fields move only on a transfer strobe
    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> ($stable(rsp_addr_q) && $stable(rsp_data_q)));
endmodule

// File: rtl/phy_host_decode.sv
module phy_host_decode
    import phy_reg_pkg::*;
#(
    parameter int                BUS_AW     = 8,
    parameter logic [BUS_AW-1:0] REG_OFFSET = 8'hEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic              fsm_idle,
    input  logic              rd_pend,
    input  logic              wr_pend,
    input  logic              done_q,
    input  logic [PHY_AW-1:0] rsp_addr_q,
    input  logic [PHY_DW-1:0] rsp_data_q,
    output logic [REG_W-1:0]  host_rdata,
    output logic              launch_rd,
    output logic              launch_wr,
    output logic [PHY_AW-1:0] req_addr_q,
    output logic [PHY_DW-1:0] req_data_q
);
    logic hit, accept, want_rd, want_wr;

    assign hit     = (host_addr == REG_OFFSET);
    assign accept  = hit && host_wr && fsm_idle;
    assign want_rd = host_wdata[RDREQ_BIT];
    assign want_wr = host_wdata[WRREQ_BIT];

    // read request takes precedence when both bits are written
    assign launch_rd = accept && want_rd;
    assign launch_wr = accept && want_wr && !want_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q <= '0;
            req_data_q <= '0;
        end else if (accept) begin
            req_addr_q <= host_wdata[REQA_LSB +: PHY_AW];
            req_data_q <= host_wdata[REQD_LSB +: PHY_DW];
        end
    end

    always_comb begin
        host_rdata = '0;
        if (hit) begin
            host_rdata[DONE_BIT]               = done_q;
            host_rdata[RSPA_LSB +: PHY_AW]     = rsp_addr_q;
            host_rdata[RSPD_LSB +: PHY_DW]     = rsp_data_q;
            host_rdata[RDREQ_BIT]              = rd_pend;
            host_rdata[WRREQ_BIT]              = wr_pend;
            host_rdata[REQA_LSB +: PHY_AW]     = req_addr_q;
            host_rdata[REQD_LSB +: PHY_DW]     = req_data_q;
        end
    end

    // R8: both request bits start a read only
    a_r8_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && want_rd && want_wr) |=> (rd_pend && !wr_pend));

    // R9: fields are locked while a request is pending
    a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !fsm_idle |=> ($stable(req_addr_q) && $stable(req_data_q)));

    // R10: writes at other offsets leave the fields alone
    a_r10_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !hit) |=> ($stable(req_addr_q) && $stable(req_data_q)));

    // R7: reserved bits read 0
    always_comb begin
        if (rst_n) begin
            a_r7_reserved_zero: assert (host_rdata[30:28] == 3'b000 && host_rdata[13:12] == 2'b00);
        end
    end
endmodule

// File: rtl/phy_reg_access.sv
module phy_reg_access
    import phy_reg_pkg::*;
#(
    parameter int                BUS_AW     = 8,
    parameter logic [BUS_AW-1:0] REG_OFFSET = 8'hEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              phy_req_valid,
    output logic              phy_req_is_read,
    output logic [PHY_AW-1:0] phy_req_addr,
    output logic [PHY_DW-1:0] phy_req_data,
    input  logic              phy_req_ack,
    input  logic              phy_rsp_valid,
    input  logic [PHY_AW-1:0] phy_rsp_addr,
    input  logic [PHY_DW-1:0] phy_rsp_data
);
    logic              launch_rd, launch_wr;
    logic              fsm_idle, rd_pend, wr_pend;
    logic              done_q;
    logic [PHY_AW-1:0] rsp_addr_q;
    logic [PHY_DW-1:0] rsp_data_q;

    phy_host_decode #(.BUS_AW(BUS_AW), .REG_OFFSET(REG_OFFSET)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .fsm_idle   (fsm_idle),
        .rd_pend    (rd_pend),
        .wr_pend    (wr_pend),
        .done_q     (done_q),
        .rsp_addr_q (rsp_addr_q),
        .rsp_data_q (rsp_data_q),
        .host_rdata (host_rdata),
        .launch_rd  (launch_rd),
        .launch_wr  (launch_wr),
        .req_addr_q (phy_req_addr),
        .req_data_q (phy_req_data)
    );

    phy_req_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_rd   (launch_rd),
        .launch_wr   (launch_wr),
        .req_ack     (phy_req_ack),
        .req_valid   (phy_req_valid),
        .req_is_read (phy_req_is_read),
        .fsm_idle    (fsm_idle),
        .rd_pend     (rd_pend),
        .wr_pend     (wr_pend)
    );

    phy_rsp_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch_rd | launch_wr),
        .rsp_valid  (phy_rsp_valid),
        .rsp_addr   (phy_rsp_addr),
        .rsp_data   (phy_rsp_data),
        .done_q     (done_q),
        .rsp_addr_q (rsp_addr_q),
        .rsp_data_q (rsp_data_q)
    );
endmodule

// File: tb/tb_phy_reg_access.sv
`timescale 1ns/1ps
module tb_phy_reg_access;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        phy_req_valid, phy_req_is_read;
    logic [3:0]  phy_req_addr;
    logic [7:0]  phy_req_data;
    logic        phy_req_ack = 1'b0;
    logic        phy_rsp_valid = 1'b0;
    logic [3:0]  phy_rsp_addr = '0;
    logic [7:0]  phy_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    phy_reg_access dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_req_valid(phy_req_valid), .phy_req_is_read(phy_req_is_read),
        .phy_req_addr(phy_req_addr), .phy_req_data(phy_req_data),
        .phy_req_ack(phy_req_ack), .phy_rsp_valid(phy_rsp_valid),
        .phy_rsp_addr(phy_rsp_addr), .phy_rsp_data(phy_rsp_data)
    );

    // {expected is_read, host low half}
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 16'h835A}, {1'b0, 16'h4A7E}, {1'b1, 16'hC5C3},
        {1'b0, 16'h4F00}, {1'b1, 16'h80FF}, {1'b0, 16'h71FF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 8'hEC;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] v);
        host_addr = a;
        #1 v = host_rdata;
        host_addr = 8'hEC;
        #1;
    endtask

    task automatic ack_once();
        @(negedge clk); phy_req_ack = 1'b1;
        @(negedge clk); phy_req_ack = 1'b0;
    endtask

    task automatic rsp_once(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); phy_rsp_valid = 1'b1; phy_rsp_addr = a; phy_rsp_data = d;
        @(negedge clk); phy_rsp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [15:0] lo;
        logic [15:0] exp_lo;
        logic [7:0]  up_addr_data;
        host_addr = 8'hEC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_at(8'hEC, v);
        check("R1 word", v, 32'h0);
        check("R1 valid", {31'b0, phy_req_valid}, 32'h0);

        // R5 incoming transfer before the table so done is set
        rsp_once(4'h9, 8'hC3);
        read_at(8'hEC, v);
        check("R5 capture", v[31:16], 32'h0000_89C3);

        // table of requests: R2, R3, R4, R7, R8
        for (int i = 0; i < 6; i++) begin
            lo = VEC[i][15:0];
            host_write(8'hEC, {16'h0000, lo});
            exp_lo = {VEC[i][16], ~VEC[i][16], 2'b00, lo[11:0]};
            check("R2/R3 valid", {31'b0, phy_req_valid}, 32'h1);
            check("R2/R3/R8 is_read", {31'b0, phy_req_is_read}, {31'b0, VEC[i][16]});
            check("R2/R3 addr", {28'b0, phy_req_addr}, {28'b0, lo[11:8]});
            if (!VEC[i][16]) check("R3 data", {24'b0, phy_req_data}, {24'b0, lo[7:0]});
            read_at(8'hEC, v);
            check("R7 R8 low half pending", {16'b0, v[15:0]}, {16'b0, exp_lo});
            check("R4 done cleared", {31'b0, v[31]}, 32'h0);
            ack_once();
            read_at(8'hEC, v);
            check("R2/R3 bits cleared after ack", {30'b0, v[15:14]}, 32'h0);
            check("R2/R3 valid dropped", {31'b0, phy_req_valid}, 32'h0);
        end

        // R6: host writes to upper half ignored
        rsp_once(4'h5, 8'h3C);
        host_write(8'hEC, 32'h7FA5_0000);
        read_at(8'hEC, v);
        check("R6 upper half", {16'b0, v[31:16]}, 32'h0000_853C);

        // R9: writes while pending ignored
        host_write(8'hEC, 32'h0000_8621);
        host_write(8'hEC, 32'h0000_4BDD);
        read_at(8'hEC, v);
        check("R9 low half locked", {16'b0, v[15:0]}, 32'h0000_8621);
        check("R9 still read", {31'b0, phy_req_is_read}, 32'h1);
        ack_once();
        @(negedge clk);
        check("R9 no second request", {31'b0, phy_req_valid}, 32'h0);

        // R5: transfer coincides with launching write
        @(negedge clk);
        host_addr = 8'hEC; host_wdata = 32'h0000_4312; host_wr = 1'b1;
        phy_rsp_valid = 1'b1; phy_rsp_addr = 4'hE; phy_rsp_data = 8'h77;
        @(negedge clk);
        host_wr = 1'b0; phy_rsp_valid = 1'b0;
        read_at(8'hEC, v);
        up_addr_data = v[23:16];
        check("R5 coincident done", {31'b0, v[31]}, 32'h1);
        check("R5 coincident fields", {20'b0, v[27:24], up_addr_data}, 32'h0000_0E77);
        ack_once();

        // R10: other offsets
        host_write(8'hE8, 32'h0000_8F11);
        check("R10 no request from miss", {31'b0, phy_req_valid}, 32'h0);
        read_at(8'hE8, v);
        check("R10 miss reads zero", v, 32'h0);
        read_at(8'hEC, v);
        check("R10 low half unchanged", {16'b0, v[15:0]}, 32'h0000_0312);

        // R1: reset again returns to zero
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_at(8'hEC, v);
        check("R1 word after reset", v, 32'h0);

        finish_run();
    end
endmodule